// File: doc/BRIEF.md
# Key-Sequenced Write Guard for a Configuration Register Space

This block fronts a small configuration register space on a single-cycle register bus and decides, for every write, whether it may land. The protected area opens only after two key words are written in the right order to a pair of kick registers. One register also needs a separate lock register to hold its own key. On top of that, one register can be written only once, and one register has bits that each become frozen once set.

Reads are combinational and always allowed. Writes are applied on the clock edge at which the write strobe is sampled. A write that a protection rule refuses leaves its target untouched and raises a one-cycle error pulse in the following cycle. Writes with a wrong key to a kick register are not errors; they simply lock the area.

Top module: `cfg_write_guard`

## Requirements
- R1: After synchronous reset the area is locked (both kick addresses read 0), the privilege register at 0x41C reads 0xAAAAAAAA, every other mapped register reads 0, and `bus_err` is low.
- R2: Reads of every address are allowed in any lock state. Unmapped addresses read 0, and a write to them changes nothing and raises no error.
- R3: Writing 0x83E70B13 to 0x38 and then 0x95A4F1E0 to 0x3C opens the area. While it is open, either kick address reads 1, and the protected registers (0x200, 0x204, 0x208, 0x41C) accept writes.
- R4: The second key alone, or a wrong value to 0x38 after the first key, does not open the area. The sequence must restart with the first key.
- R5: While open, a non-key value written to 0x38 or 0x3C locks the area again. Rewriting the first key to 0x38 keeps it open.
- R6: While locked, a write to a protected register leaves it unchanged and sets `bus_err` in the next cycle.
- R7: The kick registers and the lock register at 0x40004 accept writes in any state, without error. The lock register reads back its value.
- R8: The register at 0x40008 accepts a write only while the area is open and 0x40004 holds 0x0F0A0B00. Otherwise the write is refused with an error.
- R9: Register 0x204 keeps the value of its first accepted write. Any later write to it is refused with an error.
- R10: In register 0x208 an accepted write updates only the bits that are not yet frozen, and freezes every bit it writes as 1. Frozen bits never change, and no error is raised.
- R11: `bus_err` is high only in the one cycle after a refused write.
- R12: Reset relocks the area and clears the write-once state, so 0x204 can be written once again after unlocking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| bus_err | output | 1 | One-cycle pulse after a refused write |

## Verification
A write takes effect at the edge that samples the strobe. The read path is combinational, so the new register value is visible on `bus_rdata` during the next low phase of the clock. `bus_err` is registered from the same edge and is valid for exactly that following cycle. Each step drives the strobe on a falling edge and, at the next falling edge, drops the strobe while keeping the address. It then samples both read data and error a moment later. The pulse-width check waits one more cycle and expects the error to be low.

// File: rtl/cfg_write_guard.sv
module cfg_write_guard #(
  parameter int                ADDR_W    = 20,
  parameter int                DATA_W    = 32,
  parameter logic [ADDR_W-1:0] A_KICK0   = 20'h00038,
  parameter logic [ADDR_W-1:0] A_KICK1   = 20'h0003C,
  parameter logic [ADDR_W-1:0] A_LOCK    = 20'h40004,
  parameter logic [ADDR_W-1:0] A_GATED   = 20'h40008,
  parameter logic [ADDR_W-1:0] A_PRIV    = 20'h0041C,
  parameter logic [ADDR_W-1:0] A_PLAIN   = 20'h00200,
  parameter logic [ADDR_W-1:0] A_ONCE    = 20'h00204,
  parameter logic [ADDR_W-1:0] A_OBITS   = 20'h00208,
  parameter logic [DATA_W-1:0] KEY0      = 32'h83E70B13,
  parameter logic [DATA_W-1:0] KEY1      = 32'h95A4F1E0,
  parameter logic [DATA_W-1:0] LOCK_KEY  = 32'h0F0A0B00,
  parameter logic [DATA_W-1:0] PRIV_RST  = 32'hAAAAAAAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err
);

  typedef enum logic [1:0] {KS_LOCKED, KS_HALF, KS_OPEN} kick_t;

  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  kick_t             kst;
  logic [DATA_W-1:0] lock_q, gated_q, priv_q, plain_q, once_q, obits_q, obits_flag;
  logic              once_done;

  wire hit_k0    = bus_addr == A_KICK0;
  wire hit_k1    = bus_addr == A_KICK1;
  wire hit_lock  = bus_addr == A_LOCK;
  wire hit_gated = bus_addr == A_GATED;
  wire hit_priv  = bus_addr == A_PRIV;
  wire hit_plain = bus_addr == A_PLAIN;
  wire hit_once  = bus_addr == A_ONCE;
  wire hit_obits = bus_addr == A_OBITS;

  wire is_open   = kst == KS_OPEN;
  wire prot_hit  = hit_priv | hit_plain | hit_once | hit_obits | hit_gated;
  wire deny      = bus_we && prot_hit &&
                   (!is_open ||
                    (hit_gated && lock_q != LOCK_KEY) ||
                    (hit_once && once_done));
  wire accept    = bus_we && !deny;

  // kick handshake
  always_ff @(posedge clk) begin
    if (rst) kst <= KS_LOCKED;
    else if (bus_we && hit_k0) begin
      if (bus_wdata != KEY0) kst <= KS_LOCKED;
      else if (kst != KS_OPEN) kst <= KS_HALF;
    end else if (bus_we && hit_k1) begin
      if (bus_wdata != KEY1) kst <= KS_LOCKED;
      else if (kst == KS_HALF) kst <= KS_OPEN;
    end
  end

  // register file
  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q     <= '0;
      gated_q    <= '0;
      priv_q     <= PRIV_RST;
      plain_q    <= '0;
      once_q     <= '0;
      once_done  <= 1'b0;
      obits_q    <= '0;
      obits_flag <= '0;
      bus_err    <= 1'b0;
    end else begin
      bus_err <= deny;
      if (accept) begin
        if (hit_lock)  lock_q  <= bus_wdata;
        if (hit_gated) gated_q <= bus_wdata;
        if (hit_priv)  priv_q  <= bus_wdata;
        if (hit_plain) plain_q <= bus_wdata;
        if (hit_once) begin
          once_q    <= bus_wdata;
          once_done <= 1'b1;
        end
        if (hit_obits) begin
          obits_q    <= (obits_q & obits_flag) | (bus_wdata & ~obits_flag);
          obits_flag <= obits_flag | bus_wdata;
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_k0 || hit_k1) bus_rdata = is_open ? ONE : '0;
    else if (hit_lock)    bus_rdata = lock_q;
    else if (hit_gated)   bus_rdata = gated_q;
    else if (hit_priv)    bus_rdata = priv_q;
    else if (hit_plain)   bus_rdata = plain_q;
    else if (hit_once)    bus_rdata = once_q;
    else if (hit_obits)   bus_rdata = obits_q;
  end

  AST_OPEN_AFTER_KEY1: assert property (@(posedge clk) disable iff (rst)
    $rose(kst == KS_OPEN) |-> $past(bus_we && hit_k1 && bus_wdata == KEY1)); // R3
  AST_LOCKED_ERR: assert property (@(posedge clk) disable iff (rst)
    (bus_we && (hit_plain || hit_priv) && kst != KS_OPEN) |=> bus_err); // R6
  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_we && hit_priv && kst != KS_OPEN) |=> $stable(priv_q)); // R6
  AST_GATE_KEY: assert property (@(posedge clk) disable iff (rst)
    (bus_we && hit_gated && lock_q != LOCK_KEY) |=> $stable(gated_q)); // R8
  AST_ONCE_HOLD: assert property (@(posedge clk) disable iff (rst)
    once_done |=> (once_done && $stable(once_q))); // R9
  AST_BITS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (bus_we && hit_obits) |=> ((obits_q ^ $past(obits_q)) & $past(obits_flag)) == '0); // R10
  AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_we) |-> !bus_err); // R11

endmodule

// File: tb/cfg_write_guard_test.sv
module cfg_write_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] K0 = 32'h83E70B13;
  localparam logic [31:0] K1 = 32'h95A4F1E0;
  localparam logic [31:0] LK = 32'h0F0A0B00;

  typedef struct packed {
    logic [3:0]  req;
    logic        we;
    logic [19:0] addr;
    logic [31:0] wd;
    logic [31:0] rd;
    logic        err;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VEC [NV] = '{
    '{4'd1,  1'b0, 20'h0041C, 32'h0,        32'hAAAAAAAA, 1'b0}, // R1
    '{4'd1,  1'b0, 20'h00038, 32'h0,        32'h0,        1'b0}, // R1
    '{4'd6,  1'b1, 20'h00200, 32'h1234,     32'h0,        1'b1}, // R6
    '{4'd2,  1'b0, 20'h00200, 32'h0,        32'h0,        1'b0}, // R2
    '{4'd4,  1'b1, 20'h0003C, K1,           32'h0,        1'b0}, // R4
    '{4'd4,  1'b1, 20'h00038, K0,           32'h0,        1'b0}, // R4
    '{4'd4,  1'b1, 20'h00038, 32'h5,        32'h0,        1'b0}, // R4
    '{4'd4,  1'b1, 20'h0003C, K1,           32'h0,        1'b0}, // R4
    '{4'd3,  1'b1, 20'h00038, K0,           32'h0,        1'b0}, // R3
    '{4'd3,  1'b1, 20'h0003C, K1,           32'h1,        1'b0}, // R3
    '{4'd3,  1'b1, 20'h00200, 32'h1234,     32'h1234,     1'b0}, // R3
    '{4'd7,  1'b1, 20'h40004, 32'h11,       32'h11,       1'b0}, // R7
    '{4'd8,  1'b1, 20'h40008, 32'hBEEF,     32'h0,        1'b1}, // R8
    '{4'd7,  1'b1, 20'h40004, LK,           LK,           1'b0}, // R7
    '{4'd8,  1'b1, 20'h40008, 32'hBEEF,     32'hBEEF,     1'b0}, // R8
    '{4'd9,  1'b1, 20'h00204, 32'hA5,       32'hA5,       1'b0}, // R9
    '{4'd9,  1'b1, 20'h00204, 32'h5A,       32'hA5,       1'b1}, // R9
    '{4'd10, 1'b1, 20'h00208, 32'hF0,       32'hF0,       1'b0}, // R10
    '{4'd10, 1'b1, 20'h00208, 32'h0F,       32'hFF,       1'b0}, // R10
    '{4'd10, 1'b1, 20'h00208, 32'h100,      32'h1FF,      1'b0}, // R10
    '{4'd2,  1'b1, 20'h00300, 32'hFFFF,     32'h0,        1'b0}, // R2
    '{4'd5,  1'b1, 20'h00038, 32'h0,        32'h0,        1'b0}, // R5
    '{4'd7,  1'b1, 20'h40004, 32'h77,       32'h77,       1'b0}, // R7
    '{4'd6,  1'b1, 20'h0041C, 32'h1,        32'hAAAAAAAA, 1'b1}, // R6
    '{4'd8,  1'b1, 20'h40008, 32'h1,        32'hBEEF,     1'b1}, // R8
    '{4'd3,  1'b1, 20'h00038, K0,           32'h0,        1'b0}, // R3
    '{4'd3,  1'b1, 20'h0003C, K1,           32'h1,        1'b0}, // R3
    '{4'd5,  1'b1, 20'h0003C, 32'h2,        32'h0,        1'b0}, // R5
    '{4'd6,  1'b1, 20'h0041C, 32'h1,        32'hAAAAAAAA, 1'b1}, // R6
    '{4'd3,  1'b1, 20'h00038, K0,           32'h0,        1'b0}, // R3
    '{4'd3,  1'b1, 20'h0003C, K1,           32'h1,        1'b0}, // R3
    '{4'd6,  1'b1, 20'h0041C, 32'h12345678, 32'h12345678, 1'b0}, // R6
    '{4'd5,  1'b1, 20'h00038, K0,           32'h1,        1'b0}  // R5
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  int          nchk = 0;
  int          nbad = 0;

  cfg_write_guard uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .bus_err(bus_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(input logic we, input logic [19:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(1, {31'b0, bus_err}, 32'h0); // R1
    for (int i = 0; i < NV; i++) begin
      op(VEC[i].we, VEC[i].addr, VEC[i].wd);
      check(int'(VEC[i].req), bus_rdata, VEC[i].rd);
      check(int'(VEC[i].req), {31'b0, bus_err}, {31'b0, VEC[i].err});
    end
    // R11: refused write pulses error for one cycle only
    op(1'b1, 20'h00038, 32'h0);
    op(1'b1, 20'h00200, 32'hDEAD);
    check(11, {31'b0, bus_err}, 32'h1);
    @(negedge clk); #1;
    check(11, {31'b0, bus_err}, 32'h0);
    check(11, bus_rdata, 32'h1234);
    // R12: reset relocks and clears write-once state
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    op(1'b0, 20'h0003C, 32'h0);
    check(12, bus_rdata, 32'h0);
    op(1'b0, 20'h0041C, 32'h0);
    check(12, bus_rdata, 32'hAAAAAAAA);
    op(1'b0, 20'h00208, 32'h0);
    check(12, bus_rdata, 32'h0);
    op(1'b1, 20'h00038, K0);
    op(1'b1, 20'h0003C, K1);
    op(1'b1, 20'h00204, 32'h3);
    check(12, bus_rdata, 32'h3);
    check(12, {31'b0, bus_err}, 32'h0);
    op(1'b1, 20'h00208, 32'h0);
    check(12, bus_rdata, 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule